// File: doc/BRIEF.md
# Lane-Counted PHY Power Sequencer

This block powers a shared multi-lane PHY up and down on behalf of independent lane users. Each user sends an enable or a disable request that carries its lane number. The block keeps a count of enabled lanes. Only the enable that finds the count at zero starts a power-up sequence. The sequence releases the PHY reset and wakes every lane. It then drives a narrow indirect configuration bus: it polls for PLL lock, writes the fixed-rate mode and the reference-output enable, waits for the reference output to ungate, and finally waits for the PLL to lock again.

Each wait is a bounded loop. A poll timer spaces the reads a parameterised number of cycles apart. After a parameterised number of failed reads, the block gives up and reports a timeout code that names the phase. A disable parks only the requesting lane. The disable that takes the count back to zero puts the PHY back into reset. Requests are accepted only while no sequence is running. Every accepted request gets exactly one response pulse with a result code.

Top module: `phy_bringup_seq`

## Requirements
- R1: After reset, `phy_rst_o` is 1, every bit of `lane_idle_o` is 1, `req_ready_o` is 1 and `rsp_valid_o` is 0.
- R2: An enable accepted at count 0 deasserts `phy_rst_o` at the acceptance edge. One cycle later it clears all bits of `lane_idle_o`, and polling starts after that.
- R3: Lock wait: the block reads address 0x10 and needs bit 1 = 1. It makes at most POLL_MAX reads, spaced INTERVAL cycles apart. If the bit never sets, it responds with code 1.
- R4: Once lock is seen, the block issues exactly two single-cycle `cfg_wr_o` writes, in this order: data 0x8 to address 0x10, then data 0x8 to address 0x12. A power-up that fails the lock wait issues no write.
- R5: Ungate wait: the block reads address 0x12 and needs bit 2 = 0, with the same bound. If the bit never clears, it responds with code 2.
- R6: Relock wait: the block reads address 0x10 bit 1 again, with the same bound. On timeout it responds with code 3. On success it responds with code 0.
- R7: An enable at a nonzero count increments the count. It answers with code 0 on the cycle after acceptance and causes no configuration traffic.
- R8: A disable at a nonzero count decrements the count, sets the idle bit of its own lane only, and answers with code 0 on the next cycle. When the count reaches 0, `phy_rst_o` goes to 1 at that same edge.
- R9: A disable at count 0 answers with code 4 and leaves the count, `lane_idle_o` and `phy_rst_o` unchanged.
- R10: On any timeout, the count returns to 0, `phy_rst_o` goes to 1 and all lanes go idle, all at the edge that raises the response.
- R11: `req_ready_o` is 0 from the cycle after a power-up is accepted until its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_on_i | input | 1 | 1 = enable, 0 = disable |
| req_lane_i | input | LANE_W | Requesting lane |
| req_ready_o | output | 1 | Request accepted this cycle when high with valid |
| rsp_valid_o | output | 1 | One-cycle response pulse |
| rsp_code_o | output | 3 | 0 ok, 1 lock timeout, 2 ungate timeout, 3 relock timeout, 4 unpaired disable |
| phy_rst_o | output | 1 | PHY reset, active high |
| lane_idle_o | output | LANES | Per-lane idle control |
| cfg_addr_o | output | 6 | Configuration bus address |
| cfg_wdata_o | output | 4 | Configuration write data |
| cfg_wr_o | output | 1 | Configuration write strobe |
| cfg_rdata_i | input | 4 | Configuration read data for `cfg_addr_o` |

## Verification
The bench drives a disable at count zero, both before and after a failed power-up. A design without the underflow guard, or without the rollback on failure, would wrap the count or answer 0 there. The bench forces each of the three waits to time out in turn and checks the code and the timeout latency. Swapped codes, a poll bound off by one, or writes issued before lock would show up as a wrong code, a latency outside the window, or a wrong write log. Its PHY model sets the idle bits of the other read-data bits to ones, so that a wrong bit select is caught. It also checks that the lane wake follows the reset release by exactly one cycle, and that a disable parks only its own lane.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [2:0] {
        RSP_OK        = 3'd0,
        RSP_LOCK_TO   = 3'd1,
        RSP_GATE_TO   = 3'd2,
        RSP_RELOCK_TO = 3'd3,
        RSP_UNPAIRED  = 3'd4
    } rsp_code_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAKE,
        ST_LOCK,
        ST_WR_REF,
        ST_GATE,
        ST_RELOCK
    } seq_state_e;

    localparam logic [5:0] CFG_PLL_ADDR = 6'h10;
    localparam logic [5:0] CFG_CLK_ADDR = 6'h12;
    localparam int         LOCK_BIT     = 1;
    localparam int         GATE_BIT     = 2;
    localparam logic [3:0] RATE_FIXED   = 4'b1000;
    localparam logic [3:0] REFOUT_ON    = 4'b1000;

    typedef struct packed {
        seq_state_e  st;
        logic        phy_rst;
        logic        rsp_v;
        rsp_code_e   code;
        logic [5:0]  addr;
        logic [3:0]  wdata;
        logic        wr;
    } ctl_t;

endpackage

// File: rtl/pwrseq_poll.sv
module pwrseq_poll #(
    parameter int INTERVAL = 100000,
    parameter int POLL_MAX = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic retry,
    output logic due,
    output logic last
);
    localparam int TW = $clog2(INTERVAL + 1);
    localparam int PW = $clog2(POLL_MAX + 1);

    typedef struct packed {
        logic [TW-1:0] tick;
        logic [PW-1:0] polls;
    } poll_t;

    poll_t q, d;

    always_comb begin
        d = q;
        if (arm) begin
            d.tick  = TW'(1);
            d.polls = '0;
        end else if (retry) begin
            d.tick  = TW'(INTERVAL - 1);
            d.polls = q.polls + PW'(1);
        end else if (q.tick != '0) begin
            d.tick = q.tick - TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign due  = (q.tick == '0);
    assign last = (q.polls == PW'(POLL_MAX - 1));

    // R3: the number of reads in one wait never passes the bound
    p_poll_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        q.polls < PW'(POLL_MAX));
    // R3: the sequencer never asks for another read after the final one
    p_no_retry_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
        retry |-> !last);
endmodule

// File: rtl/pwrseq_lanes.sv
module pwrseq_lanes #(
    parameter int LANES  = 4,
    parameter int CNT_W  = 4,
    parameter int LANE_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic              dec,
    input  logic              drop,
    input  logic              wake,
    input  logic              park,
    input  logic [LANE_W-1:0] lane,
    output logic [CNT_W-1:0]  cnt,
    output logic [LANES-1:0]  idle
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [LANES-1:0] idle;
    } lanes_t;

    lanes_t q, d;

    always_comb begin
        d = q;
        if (drop) begin
            d.cnt  = '0;
            d.idle = '1;
        end else begin
            if (inc)  d.cnt = q.cnt + CNT_W'(1);
            if (dec)  d.cnt = q.cnt - CNT_W'(1);
            if (wake) d.idle = '0;
            if (park) d.idle[lane] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt  <= '0;
            q.idle <= '1;
        end else begin
            q <= d;
        end
    end

    assign cnt  = q.cnt;
    assign idle = q.idle;

    // R9: a decrement is never requested at zero
    p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> q.cnt != '0);
    // R7: an increment never wraps the count
    p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> q.cnt != '1);
    // R10: a drop leaves no lane awake
    p_drop_parks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> (q.idle == '1 && q.cnt == '0));
endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq #(
    parameter int LANES    = 4,
    parameter int CNT_W    = 4,
    parameter int POLL_MAX = 100,
    parameter int INTERVAL = 100000,
    parameter int LANE_W   = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic              req_on_i,
    input  logic [LANE_W-1:0] req_lane_i,
    output logic              req_ready_o,
    output logic              rsp_valid_o,
    output logic [2:0]        rsp_code_o,
    output logic              phy_rst_o,
    output logic [LANES-1:0]  lane_idle_o,
    output logic [5:0]        cfg_addr_o,
    output logic [3:0]        cfg_wdata_o,
    output logic              cfg_wr_o,
    input  logic [3:0]        cfg_rdata_i
);
    import pwrseq_pkg::*;

    ctl_t q, d;
    logic arm, retry, due, last;
    logic inc, dec, drop, wake, park;
    logic [CNT_W-1:0] cnt;
    logic unused_rdata;

    assign unused_rdata = ^{cfg_rdata_i[3], cfg_rdata_i[0]};

    pwrseq_poll #(.INTERVAL(INTERVAL), .POLL_MAX(POLL_MAX)) u_poll (
        .clk(clk), .rst_n(rst_n), .arm(arm), .retry(retry),
        .due(due), .last(last)
    );

    pwrseq_lanes #(.LANES(LANES), .CNT_W(CNT_W), .LANE_W(LANE_W)) u_lanes (
        .clk(clk), .rst_n(rst_n), .inc(inc), .dec(dec), .drop(drop),
        .wake(wake), .park(park), .lane(req_lane_i),
        .cnt(cnt), .idle(lane_idle_o)
    );

    always_comb begin
        d     = q;
        d.rsp_v = 1'b0;
        d.wr  = 1'b0;
        arm   = 1'b0;
        retry = 1'b0;
        inc   = 1'b0;
        dec   = 1'b0;
        drop  = 1'b0;
        wake  = 1'b0;
        park  = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid_i) begin
                    if (req_on_i) begin
                        inc = 1'b1;
                        if (cnt == '0) begin
                            d.phy_rst = 1'b0;
                            d.st      = ST_WAKE;
                        end else begin
                            d.rsp_v = 1'b1;
                            d.code  = RSP_OK;
                        end
                    end else if (cnt == '0) begin
                        d.rsp_v = 1'b1;
                        d.code  = RSP_UNPAIRED;
                    end else begin
                        dec     = 1'b1;
                        park    = 1'b1;
                        d.rsp_v = 1'b1;
                        d.code  = RSP_OK;
                        if (cnt == CNT_W'(1)) d.phy_rst = 1'b1;
                    end
                end
            end
            ST_WAKE: begin
                wake   = 1'b1;
                arm    = 1'b1;
                d.addr = CFG_PLL_ADDR;
                d.st   = ST_LOCK;
            end
            ST_LOCK: begin
                if (due) begin
                    if (cfg_rdata_i[LOCK_BIT]) begin
                        d.wr    = 1'b1;
                        d.addr  = CFG_PLL_ADDR;
                        d.wdata = RATE_FIXED;
                        d.st    = ST_WR_REF;
                    end else if (last) begin
                        d.rsp_v = 1'b1; d.code = RSP_LOCK_TO;
                        d.phy_rst = 1'b1; drop = 1'b1; d.st = ST_IDLE;
                    end else begin
                        retry = 1'b1;
                    end
                end
            end
            ST_WR_REF: begin
                d.wr    = 1'b1;
                d.addr  = CFG_CLK_ADDR;
                d.wdata = REFOUT_ON;
                arm     = 1'b1;
                d.st    = ST_GATE;
            end
            ST_GATE: begin
                if (due) begin
                    if (!cfg_rdata_i[GATE_BIT]) begin
                        d.addr = CFG_PLL_ADDR;
                        arm    = 1'b1;
                        d.st   = ST_RELOCK;
                    end else if (last) begin
                        d.rsp_v = 1'b1; d.code = RSP_GATE_TO;
                        d.phy_rst = 1'b1; drop = 1'b1; d.st = ST_IDLE;
                    end else begin
                        retry = 1'b1;
                    end
                end
            end
            ST_RELOCK: begin
                if (due) begin
                    if (cfg_rdata_i[LOCK_BIT]) begin
                        d.rsp_v = 1'b1; d.code = RSP_OK; d.st = ST_IDLE;
                    end else if (last) begin
                        d.rsp_v = 1'b1; d.code = RSP_RELOCK_TO;
                        d.phy_rst = 1'b1; drop = 1'b1; d.st = ST_IDLE;
                    end else begin
                        retry = 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.st      <= ST_IDLE;
            q.code    <= RSP_OK;
            q.phy_rst <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign req_ready_o = (q.st == ST_IDLE);
    assign rsp_valid_o = q.rsp_v;
    assign rsp_code_o  = q.code;
    assign phy_rst_o   = q.phy_rst;
    assign cfg_addr_o  = q.addr;
    assign cfg_wdata_o = q.wdata;
    assign cfg_wr_o    = q.wr;

    // R2: lanes are woken only after the reset release of the prior cycle
    p_wake_after_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WAKE) |-> (!phy_rst_o && $past(q.st) == ST_IDLE));
    // R4: every write carries one of the two permitted address/data pairs
    p_write_pairs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_o |-> ((cfg_addr_o == CFG_PLL_ADDR && cfg_wdata_o == RATE_FIXED) ||
                      (cfg_addr_o == CFG_CLK_ADDR && cfg_wdata_o == REFOUT_ON)));
    // R8: when at rest, reset is held exactly when no lane is counted
    p_rst_tracks_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |-> (phy_rst_o == (cnt == '0)));
    // R9: an unpaired answer is only given with an empty count
    p_unpaired_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && rsp_code_o == 3'd4) |-> (cnt == '0));
endmodule

// File: tb/phy_bringup_seq_test.sv
`timescale 1ns/1ps
module phy_bringup_seq_test;
    localparam int LANES = 4;
    localparam int POLL_MAX = 6;
    localparam int INTERVAL = 8;
    localparam int LOCK_DLY = 10;
    localparam int GATE_DLY = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_on = 1'b0;
    logic [1:0] req_lane = '0;
    logic req_ready, rsp_valid, phy_rst, cfg_wr;
    logic [2:0] rsp_code;
    logic [LANES-1:0] lane_idle;
    logic [5:0] cfg_addr;
    logic [3:0] cfg_wdata, cfg_rdata;

    always #2.5 clk = ~clk;

    phy_bringup_seq #(.LANES(LANES), .CNT_W(4), .POLL_MAX(POLL_MAX),
                      .INTERVAL(INTERVAL)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_on_i(req_on),
        .req_lane_i(req_lane), .req_ready_o(req_ready), .rsp_valid_o(rsp_valid),
        .rsp_code_o(rsp_code), .phy_rst_o(phy_rst), .lane_idle_o(lane_idle),
        .cfg_addr_o(cfg_addr), .cfg_wdata_o(cfg_wdata), .cfg_wr_o(cfg_wr),
        .cfg_rdata_i(cfg_rdata)
    );

    // PHY model
    logic lock_en = 1'b1, ungate_en = 1'b1, relock_en = 1'b1;
    logic lock_q, gate_q, rate_set, gate_arm;
    int lock_cnt, gate_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n || phy_rst) begin
            lock_q <= 1'b0; gate_q <= 1'b1; rate_set <= 1'b0; gate_arm <= 1'b0;
            lock_cnt <= 0; gate_cnt <= 0;
        end else begin
            if (cfg_wr && cfg_addr == 6'h10) begin
                lock_q <= 1'b0; lock_cnt <= 0; rate_set <= 1'b1;
            end else if (!lock_q) begin
                lock_cnt <= lock_cnt + 1;
                if (lock_cnt >= LOCK_DLY && (rate_set ? relock_en : lock_en)) lock_q <= 1'b1;
            end
            if (cfg_wr && cfg_addr == 6'h12) gate_arm <= 1'b1;
            if (gate_arm) begin
                gate_cnt <= gate_cnt + 1;
                if (gate_cnt >= GATE_DLY && ungate_en) gate_q <= 1'b0;
            end
        end
    end
    assign cfg_rdata = (cfg_addr == 6'h10) ? {1'b1, 1'b0, lock_q, 1'b1} :
                       (cfg_addr == 6'h12) ? {1'b1, gate_q, 2'b11} : 4'h0;

    int checks = 0, errors = 0, cyc = 0;
    logic [2:0] exp_q[$];
    string tag_q[$];
    logic [9:0] wlog[$];
    int acc_cyc, rsp_cyc, rst_fall_cyc, wake_cyc;
    logic rdy_after, prev_rst = 1'b1;
    logic [LANES-1:0] prev_idle = '1;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // monitor: scoreboard pop, write log, edge stamps
    always @(negedge clk) begin
        if (rst_n) begin
            if (cfg_wr) wlog.push_back({cfg_addr, cfg_wdata});
            if (prev_rst && !phy_rst) rst_fall_cyc = cyc;
            if (prev_idle == '1 && lane_idle != '1) wake_cyc = cyc;
            prev_rst = phy_rst; prev_idle = lane_idle;
            if (rsp_valid) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R1", "unexpected response", int'(rsp_code), -1);
                end else begin
                    automatic logic [2:0] e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    chk(rsp_code == e, t, "response code", int'(rsp_code), int'(e));
                    rsp_cyc = cyc;
                end
            end
        end
    end

    task automatic send(input bit on, input int lane, input logic [2:0] code,
                        input string req);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        wlog.delete();
        req_valid = 1'b1; req_on = on; req_lane = 2'(lane);
        exp_q.push_back(code); tag_q.push_back(req);
        @(negedge clk);
        acc_cyc = cyc;
        rdy_after = req_ready;
        req_valid = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(phy_rst == 1'b1, "R1", "phy_rst in reset", phy_rst, 1);
        chk(lane_idle == 4'hF, "R1", "idle in reset", lane_idle, 15);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        chk(rsp_valid == 1'b0, "R1", "no response after reset", rsp_valid, 0);

        send(0, 2, 3'd4, "R9");
        chk(lane_idle == 4'hF && phy_rst, "R9", "state after unpaired", lane_idle, 15);

        send(1, 0, 3'd0, "R6");
        chk(rdy_after == 1'b0, "R11", "ready during power-up", rdy_after, 0);
        chk(!phy_rst && lane_idle == 4'h0, "R2", "powered lanes", lane_idle, 0);
        chk(wake_cyc - rst_fall_cyc == 1, "R2", "wake after release", wake_cyc - rst_fall_cyc, 1);
        chk(wlog.size() == 2, "R4", "write count", wlog.size(), 2);
        if (wlog.size() == 2) begin
            chk(wlog[0] == {6'h10, 4'h8}, "R4", "first write", wlog[0], {6'h10, 4'h8});
            chk(wlog[1] == {6'h12, 4'h8}, "R4", "second write", wlog[1], {6'h12, 4'h8});
        end

        send(1, 1, 3'd0, "R7");
        chk(rsp_cyc - acc_cyc == 0, "R7", "fast enable latency", rsp_cyc - acc_cyc, 0);
        chk(wlog.size() == 0, "R7", "no config writes", wlog.size(), 0);

        send(0, 1, 3'd0, "R8");
        chk(lane_idle == 4'b0010 && !phy_rst, "R8", "park own lane", lane_idle, 2);
        send(0, 0, 3'd0, "R8");
        chk(lane_idle == 4'b0011 && phy_rst, "R8", "last disable resets", lane_idle, 3);
        send(0, 3, 3'd4, "R9");
        chk(lane_idle == 4'b0011 && phy_rst, "R9", "unpaired no change", lane_idle, 3);

        lock_en = 1'b0;
        send(1, 0, 3'd1, "R3");
        chk((rsp_cyc - acc_cyc) >= (POLL_MAX - 1) * INTERVAL &&
            (rsp_cyc - acc_cyc) <= (POLL_MAX - 1) * INTERVAL + 10,
            "R3", "lock timeout latency", rsp_cyc - acc_cyc, (POLL_MAX - 1) * INTERVAL + 3);
        chk(wlog.size() == 0, "R4", "no writes without lock", wlog.size(), 0);
        chk(phy_rst && lane_idle == 4'hF, "R10", "rollback after lock timeout", lane_idle, 15);
        send(0, 0, 3'd4, "R10");

        lock_en = 1'b1; ungate_en = 1'b0;
        send(1, 2, 3'd2, "R5");
        chk(wlog.size() == 2, "R5", "writes before ungate wait", wlog.size(), 2);
        chk(phy_rst && lane_idle == 4'hF, "R10", "rollback after ungate timeout", lane_idle, 15);

        ungate_en = 1'b1; relock_en = 1'b0;
        send(1, 3, 3'd3, "R6");
        chk(phy_rst && lane_idle == 4'hF, "R10", "rollback after relock timeout", lane_idle, 15);

        relock_en = 1'b1;
        send(1, 3, 3'd0, "R6");
        chk(!phy_rst && lane_idle == 4'h0, "R6", "power-up after failures", lane_idle, 0);
        send(0, 3, 3'd0, "R8");
        chk(lane_idle == 4'b1000 && phy_rst, "R8", "park lane 3", lane_idle, 8);

        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule